// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles, producing one quotient bit per cycle with a single subtractor. A pulse on `start` captures both operands. While the operation runs, `busy` stays high. When the result is ready, `done` pulses for one cycle and `quotient` and `remainder` hold the answer until the next division finishes. The `signed_mode` input chooses between unsigned and two's-complement division.

All arithmetic is done on magnitudes in a single left-shifting accumulator. The upper part holds the partial remainder and the lower part collects the quotient bits. Each step trial-subtracts the divisor and keeps the difference only when it is non-negative. In signed mode the signs are recorded at the start and applied to the outputs when the result is written. A zero divisor is caught at the start and answered at once with a flag.

Top module: `seq_divider`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: With `signed_mode`=0, the operands are unsigned and the result is `quotient` = floor(dividend/divisor) and `remainder` = dividend - quotient*divisor. This holds for the full range, including a dividend of all ones and a divisor of all ones.
- R3: When `start` is sampled high at clock edge k with a non-zero divisor and `busy` low, `busy` is high after edges k through k+WIDTH-1. After edge k+WIDTH, `busy` is low and `done` is high, so the latency is WIDTH cycles.
- R4: `done` is high for exactly one cycle per accepted operation.
- R5: `start` sampled while `busy` is high has no effect. `busy` stays high, and the result and `div_by_zero` reflect only the operands that were accepted.
- R6: With `signed_mode`=1, the operands are two's complement. The quotient is truncated toward zero and is negated when the operand signs differ (-7/2 gives -3). The most negative value divided by -1 wraps to the most negative value.
- R7: In signed mode the remainder takes the sign of the dividend (-7/2 gives remainder -1, 7/-2 gives remainder 1). In both modes the remainder magnitude is below the divisor magnitude.
- R8: A zero divisor accepted at edge k makes `done` and `div_by_zero` high after edge k, and `busy` never rises. The values of `quotient` and `remainder` are then unspecified.
- R9: `div_by_zero` is updated on every `done`. It reads 0 after a division with a non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division with the present operands (taken only when idle) |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | WIDTH | Registered quotient |
| remainder | output | WIDTH | Registered remainder |
| div_by_zero | output | 1 | Last completed operation had a zero divisor |

## Verification
The bench targets the operands where a restoring loop most easily breaks:
- A divisor with its top bit set. This overflows a partial remainder that lacks a carry bit and gives wrong quotients.
- All four sign combinations. A wrong sign rule shows up as a positive remainder for a negative dividend, or as a quotient rounded the wrong way.
- The most negative value divided by -1, and a dividend of all ones divided by one. These expose missing magnitude bits.
- A forgotten final right shift. This would return twice the true remainder.

The bench also fires `start`, including one with a zero divisor, in the middle of a division. A design that accepts it would corrupt the result or raise the flag. A zero-divisor division followed by a normal one checks that the flag clears.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_phase_t;

  function automatic int unsigned cnt_bits(input int unsigned w);
    return $clog2(w) + 1;
  endfunction
endpackage

// File: rtl/div_operand_abs.sv
module div_operand_abs #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  input  logic             use_sign,
  output logic [WIDTH-1:0] magnitude,
  output logic             is_neg
);
  always_comb begin
    is_neg    = use_sign & value[WIDTH-1];
    magnitude = is_neg ? (~value + 1'b1) : value;
  end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int WIDTH = 32,
  localparam int AW = 2*WIDTH + 1
) (
  input  logic [AW-1:0]    acc,
  input  logic [WIDTH-1:0] dvs,
  output logic [AW-1:0]    acc_next,
  output logic             qbit
);
  logic [WIDTH:0]   upper;
  logic [WIDTH+1:0] diff;
  logic [WIDTH:0]   kept;

  always_comb begin
    upper    = acc[AW-1:WIDTH];
    diff     = {1'b0, upper} - {2'b00, dvs};
    qbit     = ~diff[WIDTH+1];
    // restore: keep the old upper part when the trial went negative
    kept     = qbit ? diff[WIDTH:0] : upper;
    acc_next = {kept[WIDTH-1:0], acc[WIDTH-1:0], qbit};
  end

  // Kept partial remainder must fit under the divisor, so its carry bit is clear.
  always_comb begin
    if (dvs != '0 && upper < {dvs, 1'b0})
      a_kept_fits_r7: assert (kept[WIDTH] == 1'b0 && kept[WIDTH-1:0] < dvs);
  end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] mag,
  input  logic             negate,
  output logic [WIDTH-1:0] result
);
  always_comb result = negate ? (~mag + 1'b1) : mag;
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  localparam int AW = 2*WIDTH + 1;
  localparam int CW = cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_phase_t       phase;
  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] dvs_mag;
  logic [CW-1:0]    iter;
  logic             neg_quo, neg_rem;

  logic [WIDTH-1:0] a_mag, b_mag;
  logic             a_neg, b_neg;
  logic [AW-1:0]    acc_next;
  logic             qbit;
  logic [WIDTH-1:0] quo_fixed, rem_fixed;

  div_operand_abs #(.WIDTH(WIDTH)) u_abs_num (
    .value(dividend), .use_sign(signed_mode), .magnitude(a_mag), .is_neg(a_neg)
  );
  div_operand_abs #(.WIDTH(WIDTH)) u_abs_den (
    .value(divisor), .use_sign(signed_mode), .magnitude(b_mag), .is_neg(b_neg)
  );

  div_restore_step #(.WIDTH(WIDTH)) u_step (
    .acc(acc), .dvs(dvs_mag), .acc_next(acc_next), .qbit(qbit)
  );

  // the loop shifts one time too many: drop the low bit of the upper part
  div_sign_fix #(.WIDTH(WIDTH)) u_fix_quo (
    .mag(acc_next[WIDTH-1:0]), .negate(neg_quo), .result(quo_fixed)
  );
  div_sign_fix #(.WIDTH(WIDTH)) u_fix_rem (
    .mag(acc_next[AW-1:WIDTH+1]), .negate(neg_rem), .result(rem_fixed)
  );

  assign busy = (phase == DIV_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= DIV_IDLE;
      acc         <= '0;
      dvs_mag     <= '0;
      iter        <= '0;
      neg_quo     <= 1'b0;
      neg_rem     <= 1'b0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
    end else begin
      done <= 1'b0;
      if (phase == DIV_IDLE) begin
        if (start) begin
          if (divisor == '0) begin
            done        <= 1'b1;
            div_by_zero <= 1'b1;
            quotient    <= '0;
            remainder   <= '0;
          end else begin
            phase   <= DIV_RUN;
            iter    <= '0;
            // load with the first left shift already applied
            acc     <= {{WIDTH{1'b0}}, a_mag, 1'b0};
            dvs_mag <= b_mag;
            neg_quo <= a_neg ^ b_neg;
            neg_rem <= a_neg;
          end
        end
      end else begin
        acc  <= acc_next;
        iter <= iter + 1'b1;
        if (iter == LAST) begin
          phase       <= DIV_IDLE;
          done        <= 1'b1;
          div_by_zero <= 1'b0;
          quotient    <= quo_fixed;
          remainder   <= rem_fixed;
        end
      end
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_ends_done_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_busy_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && iter != LAST) |=> (busy && $stable(dvs_mag) && !done));
  p_zero_quick_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && div_by_zero && !busy));
  p_partial_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (acc[AW-1:WIDTH] < {dvs_mag, 1'b0}));
endmodule

// File: tb/seq_divider_test.sv
`timescale 1ns/1ps
module seq_divider_test;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           cyc;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  logic prev_done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seq_divider #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input bit s, input string tag);
    exp_t e;
    longint na, nb, qq, rr;
    e.tag = tag;
    e.dz  = (b == '0);
    if (e.dz) begin
      e.q = '0; e.r = '0;
    end else begin
      na = s ? longint'($signed(a)) : longint'({32'b0, a});
      nb = s ? longint'($signed(b)) : longint'({32'b0, b});
      qq = na / nb;
      rr = na % nb;
      e.q = qq[W-1:0];
      e.r = rr[W-1:0];
    end
    return e;
  endfunction

  // driver: start at a negedge, the next posedge (cycle cyc+1) samples it
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                     input string tag, input bit poke);
    exp_t e;
    @(negedge clk);
    signed_mode = s; dividend = a; divisor = b; start = 1'b1;
    e = model(a, b, s, tag);
    e.cyc = e.dz ? cyc + 1 : cyc + 1 + W;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      dividend = 32'd99; divisor = 32'd0; signed_mode = ~s; start = 1'b1;
      @(negedge clk);
      check(busy === 1'b1, "R5", "busy after ignored start", {31'b0, busy}, 1);
      dividend = 32'd7; divisor = 32'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R5", "busy after second ignored start", {31'b0, busy}, 1);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares each completion against the scoreboard head
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done)
        check(1'b0, "R4", "done longer than one cycle", 2, 1);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4", "done with nothing pending", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.cyc, e.dz ? "R8" : "R3", {e.tag, " latency"}, cyc, e.cyc);
          check(div_by_zero === e.dz, e.dz ? "R8" : "R9", {e.tag, " zero flag"},
                {31'b0, div_by_zero}, {31'b0, e.dz});
          if (!e.dz) begin
            check(quotient === e.q, "R2/R6", {e.tag, " quotient"}, quotient, e.q);
            check(remainder === e.r, "R7", {e.tag, " remainder"}, remainder, e.r);
          end else begin
            check(busy === 1'b0, "R8", {e.tag, " busy stays low"}, {31'b0, busy}, 0);
          end
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && div_by_zero === 1'b0, "R1",
          "control outputs after reset", {29'b0, busy, done, div_by_zero}, 0);
    check(quotient === '0 && remainder === '0, "R1", "data outputs after reset",
          quotient | remainder, 0);

    run(32'd100, 32'd7, 1'b0, "R2 100/7", 1'b0);
    run(32'hFFFF_FFFF, 32'd1, 1'b0, "R2 max/1", 1'b0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2 max/max", 1'b0);
    run(32'd5, 32'hFFFF_FFFF, 1'b0, "R2 small/max", 1'b0);
    run(32'hFFFF_FFFE, 32'h8000_0001, 1'b0, "R2 top-bit divisor", 1'b0);
    run(32'd7, 32'd2, 1'b1, "R6 7/2", 1'b0);
    run(-32'sd7, 32'd2, 1'b1, "R6 R7 -7/2", 1'b0);
    run(32'd7, -32'sd2, 1'b1, "R6 R7 7/-2", 1'b0);
    run(-32'sd7, -32'sd2, 1'b1, "R6 R7 -7/-2", 1'b0);
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R6 minint/-1", 1'b0);
    run(32'h8000_0000, 32'h8000_0000, 1'b1, "R6 minint/minint", 1'b0);
    run(32'h8000_0000, 32'd3, 1'b1, "R6 minint/3", 1'b0);
    run(32'd12345, 32'd0, 1'b0, "R8 unsigned zero", 1'b0);
    run(-32'sd9, 32'd0, 1'b1, "R8 signed zero", 1'b0);
    run(32'd3, 32'd5, 1'b0, "R9 after zero", 1'b0);
    run(32'd1000, 32'd3, 1'b0, "R5 poked", 1'b1);
    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] a, b;
      a = 32'h9E37_79B9 * (i + 1) + 32'h1234;
      b = (32'h0001_3579 * (i + 3)) >> (i * 3);
      run(a, b, i[0], "R2 R6 R7 sweep", 1'b0);
    end

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R4", "pending results at end", sb.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule